// File: doc/BRIEF.md
# Chained Address/Data Breakpoint Trigger Array

This block holds a small, parameterized set of breakpoint triggers. Each trigger has a control word and a compare value. When the core presents a retiring instruction or memory access, every trigger tests either the access address or the access data against its compare value. The test uses the trigger's match mode, and the trigger also filters on access kind, access size and privilege level. Neighbouring triggers can be linked with a chain bit, so that a group reports one action only when all of its links match in the same cycle. The result is a registered fire strobe with the action code of the reporting trigger, its index, and a mask of every trigger that took part.

Software reaches the triggers through a select index, a small register address and a write strobe, and reads back through a combinational data port. A global machine-level enable, with a saved copy, is cleared by traps into machine mode and restored on trap return. Triggers marked debug-only can be changed only while the core is in debug mode.

Top module: `match_trig_array`

## Requirements
- R1: Control bits [3:0] select the match mode. Mode 0 matches when the compare value equals the programmed value, and mode 8 matches when they differ. Mode codes 6, 7, 10, 11, 14 and 15 never match.
- R2: Mode 2 matches when the compare value is unsigned greater than or equal to the programmed value. Mode 3 matches when it is unsigned less than the programmed value.
- R3: Mode 1 compares only the bits above the lowest zero bit of the programmed value, so a programmed value of 0x1007 matches 0x1000 through 0x100F. Mode 9 is its inverse.
- R4: Mode 4 ANDs the low half of the compare value with the high half of the programmed value and tests the result for equality with the low half of the programmed value. Mode 5 does the same with the high half of the compare value. Modes 12 and 13 are the inverses of modes 4 and 5.
- R5: The size field, control bits [18:16], uses 0 for any size, 1 for 8-bit, 2 for 16-bit, 3 for 32-bit and 5 for 64-bit. A nonzero size matches only an access whose acc_size carries the same code.
- R6: Control bit 4 picks the compared quantity: 0 takes acc_addr and 1 takes acc_data. Bits 5, 6 and 7 enable execute, load and store accesses. Bits 8, 9 and 10 enable the user (acc_priv 0), supervisor (1) and machine (3) levels. A trigger matches only when both its access kind and its privilege level are enabled.
- R7: Bit 11 is the chain bit. A chain runs from a trigger with chain set through the first following trigger with chain clear. Only that last trigger's action, bits [15:12], is reported, and only when every member matches in the same cycle. A trigger that has chain set and no following trigger never fires.
- R8: Bit 19 is the hit flag. It becomes 1 in every trigger of a chain that fires. A control write stores whatever hit value is written, which lets software clear it.
- R9: Register address 2 holds the machine enable in bit 0 and its saved copy in bit 1, and both reset to 0. A trap_m pulse copies the enable into the saved bit and clears the enable. An mret pulse restores the enable from the saved bit. While the enable is clear, a chain whose reporting action is 0 does not fire on a machine-level access.
- R10: Control bit 27 is the debug-only flag. Outside debug mode it is written as 0, and writes to a debug-only trigger's control word or compare value are ignored. A control write that leaves bit 27 clear stores chain as 0 when the next trigger is debug-only. A write that sets bit 27 is ignored when the previous trigger has bit 27 clear and chain set.
- R11: fire_valid, fire_action, fire_idx and hit_mask update on the clock edge that samples acc_valid high, so they appear one cycle after the access. They are 0 after a cycle without an access.
- R12: After reset every control word reads 0x2000_0000 (type 2 in bits [31:28], all other fields 0), every compare value reads 0, and all outputs are 0. The type field ignores writes. Register address 0 selects the control word and address 1 the compare value.
- R13: When several chains fire in the same cycle, fire_idx and fire_action come from the lowest-indexed reporting trigger, and hit_mask covers the members of all firing chains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | IDXW | Trigger selected for register access |
| reg_addr | input | 2 | 0 control, 1 compare value, 2 machine enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | XLEN | Register write data |
| reg_rdata | output | XLEN | Register read data (combinational) |
| dbg_mode | input | 1 | Core is in debug mode |
| trap_m | input | 1 | Trap into machine mode taken |
| mret | input | 1 | Return from machine trap |
| acc_valid | input | 1 | Access presented this cycle |
| acc_ex | input | 1 | Access is an instruction execute |
| acc_ld | input | 1 | Access is a load |
| acc_st | input | 1 | Access is a store |
| acc_priv | input | 2 | Privilege level of the access |
| acc_size | input | 3 | Access size code |
| acc_addr | input | XLEN | Access address |
| acc_data | input | XLEN | Access data or instruction word |
| fire_valid | output | 1 | A chain fired on the previous access |
| fire_action | output | 4 | Action of the reporting trigger |
| fire_idx | output | IDXW | Index of the reporting trigger |
| hit_mask | output | NTRIG | Triggers that belong to firing chains |

## Verification
The hardest cases to reach are the two write-rejection rules for debug-only triggers. Each needs a neighbour to be put into a particular debug-only and chain state first, and only then can the write under test be issued, with dbg_mode switched between the steps. The stimulus builds these states one write at a time and reads the control words back to see which bits were kept. Partial chains are covered by accesses in which one link's address matches and the other link's data differs. The machine-enable sequence mixes trap and return pulses with machine-level and user-level accesses, so that gating by action code is separated from gating by privilege level.

// File: rtl/mt_pkg.sv
package mt_pkg;

    localparam logic [3:0] MT_TYPE_MATCH = 4'd2;

    localparam logic [1:0] RA_CTL = 2'd0;
    localparam logic [1:0] RA_CMP = 2'd1;
    localparam logic [1:0] RA_ENA = 2'd2;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    typedef struct packed {
        logic       dbg_only;
        logic       hit;
        logic [2:0] size;
        logic [3:0] action;
        logic       chain;
        logic       pm;
        logic       ps;
        logic       pu;
        logic       st;
        logic       ld;
        logic       ex;
        logic       sel;
        logic [3:0] mode;
    } mt_ctl_t;

endpackage

// File: rtl/mt_match.sv
module mt_match
    import mt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  mt_ctl_t           ctl,
    input  logic [XLEN-1:0]   tval,
    input  logic              acc_ex,
    input  logic              acc_ld,
    input  logic              acc_st,
    input  logic [1:0]        acc_priv,
    input  logic [2:0]        acc_size,
    input  logic [XLEN-1:0]   acc_addr,
    input  logic [XLEN-1:0]   acc_data,
    output logic              matched
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] cv;
    logic [XLEN-1:0] upper_mask;
    logic            seen_zero;
    logic            raw;
    logic            legal;
    logic            kind_ok;
    logic            priv_ok;
    logic            size_ok;

    always_comb begin
        cv = ctl.sel ? acc_data : acc_addr;

        // bits strictly above the lowest zero of the programmed value
        upper_mask = '0;
        seen_zero  = 1'b0;
        for (int b = 0; b < XLEN; b++) begin
            if (seen_zero) upper_mask[b] = 1'b1;
            if (!tval[b])  seen_zero     = 1'b1;
        end

        case (ctl.mode[2:0])
            3'd0:    raw = (cv == tval);
            3'd1:    raw = (((cv ^ tval) & upper_mask) == '0);
            3'd2:    raw = (cv >= tval);
            3'd3:    raw = (cv < tval);
            3'd4:    raw = ((cv[HALF-1:0] & tval[XLEN-1:HALF]) == tval[HALF-1:0]);
            3'd5:    raw = ((cv[XLEN-1:HALF] & tval[XLEN-1:HALF]) == tval[HALF-1:0]);
            default: raw = 1'b0;
        endcase

        legal = ctl.mode[3] ? (ctl.mode[1] == 1'b0) : (ctl.mode[2:0] <= 3'd5);

        kind_ok = (ctl.ex & acc_ex) | (ctl.ld & acc_ld) | (ctl.st & acc_st);

        case (acc_priv)
            PRIV_U:  priv_ok = ctl.pu;
            PRIV_S:  priv_ok = ctl.ps;
            PRIV_M:  priv_ok = ctl.pm;
            default: priv_ok = 1'b0;
        endcase

        size_ok = (ctl.size == 3'd0) || (ctl.size == acc_size);

        matched = legal && (raw ^ ctl.mode[3]) && kind_ok && priv_ok && size_ok;
    end

endmodule

// File: rtl/mt_chain.sv
module mt_chain #(
    parameter  int NTRIG = 4,
    localparam int IDXW  = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic [NTRIG-1:0]       link_match,
    input  logic [NTRIG-1:0]       link_chain,
    input  logic [NTRIG-1:0][3:0]  link_action,
    input  logic                   m_block,
    output logic                   any_fire,
    output logic [IDXW-1:0]        first_idx,
    output logic [3:0]             first_action,
    output logic [NTRIG-1:0]       members
);

    logic [NTRIG-1:0] end_fire;
    logic             carry;
    logic             ok;
    logic             tail;

    always_comb begin
        // forward pass: a link is good if it matches and every earlier link of its chain did
        carry    = 1'b1;
        ok       = 1'b0;
        end_fire = '0;
        for (int i = 0; i < NTRIG; i++) begin
            ok          = link_match[i] & carry;
            end_fire[i] = ok & !link_chain[i] & !(m_block && (link_action[i] == 4'd0));
            carry       = link_chain[i] ? ok : 1'b1;
        end

        // backward pass: spread a firing end over the links that feed it
        tail    = 1'b0;
        members = '0;
        for (int i = NTRIG - 1; i >= 0; i--) begin
            members[i] = end_fire[i] | (link_chain[i] & tail);
            tail       = members[i];
        end

        any_fire     = |end_fire;
        first_idx    = '0;
        first_action = '0;
        for (int i = NTRIG - 1; i >= 0; i--) begin
            if (end_fire[i]) begin
                first_idx    = IDXW'(i);
                first_action = link_action[i];
            end
        end
    end

endmodule

// File: rtl/match_trig_array.sv
module match_trig_array
    import mt_pkg::*;
#(
    parameter  int NTRIG = 4,
    parameter  int XLEN  = 32,
    localparam int IDXW  = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDXW-1:0]   reg_idx,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [XLEN-1:0]   reg_wdata,
    output logic [XLEN-1:0]   reg_rdata,
    input  logic              dbg_mode,
    input  logic              trap_m,
    input  logic              mret,
    input  logic              acc_valid,
    input  logic              acc_ex,
    input  logic              acc_ld,
    input  logic              acc_st,
    input  logic [1:0]        acc_priv,
    input  logic [2:0]        acc_size,
    input  logic [XLEN-1:0]   acc_addr,
    input  logic [XLEN-1:0]   acc_data,
    output logic              fire_valid,
    output logic [3:0]        fire_action,
    output logic [IDXW-1:0]   fire_idx,
    output logic [NTRIG-1:0]  hit_mask
);

    typedef struct packed {
        mt_ctl_t [NTRIG-1:0]           ctl;
        logic    [NTRIG-1:0][XLEN-1:0] cmp;
        logic                          en;
        logic                          en_saved;
        logic                          fire_v;
        logic    [3:0]                 fire_a;
        logic    [IDXW-1:0]            fire_i;
        logic    [NTRIG-1:0]           hits;
    } state_t;

    state_t s_d, s_q;

    function automatic logic [XLEN-1:0] ctl_pack(mt_ctl_t c);
        logic [XLEN-1:0] w;
        w                  = '0;
        w[3:0]             = c.mode;
        w[4]               = c.sel;
        w[5]               = c.ex;
        w[6]               = c.ld;
        w[7]               = c.st;
        w[8]               = c.pu;
        w[9]               = c.ps;
        w[10]              = c.pm;
        w[11]              = c.chain;
        w[15:12]           = c.action;
        w[18:16]           = c.size;
        w[19]              = c.hit;
        w[XLEN-5]          = c.dbg_only;
        w[XLEN-1:XLEN-4]   = MT_TYPE_MATCH;
        return w;
    endfunction

    function automatic mt_ctl_t ctl_unpack(logic [XLEN-1:0] w);
        mt_ctl_t c;
        c.mode     = w[3:0];
        c.sel      = w[4];
        c.ex       = w[5];
        c.ld       = w[6];
        c.st       = w[7];
        c.pu       = w[8];
        c.ps       = w[9];
        c.pm       = w[10];
        c.chain    = w[11];
        c.action   = w[15:12];
        c.size     = w[18:16];
        c.hit      = w[19];
        c.dbg_only = w[XLEN-5];
        return c;
    endfunction

    logic [NTRIG-1:0]      t_match;
    logic [NTRIG-1:0]      t_chain;
    logic [NTRIG-1:0][3:0] t_action;
    logic [NTRIG-1:0]      next_dbg;
    logic [NTRIG-1:0]      prev_lock;

    for (genvar g = 0; g < NTRIG; g++) begin : g_trig
        mt_match #(.XLEN(XLEN)) u_match (
            .ctl      (s_q.ctl[g]),
            .tval     (s_q.cmp[g]),
            .acc_ex   (acc_ex),
            .acc_ld   (acc_ld),
            .acc_st   (acc_st),
            .acc_priv (acc_priv),
            .acc_size (acc_size),
            .acc_addr (acc_addr),
            .acc_data (acc_data),
            .matched  (t_match[g])
        );
        assign t_chain[g]  = s_q.ctl[g].chain;
        assign t_action[g] = s_q.ctl[g].action;

        if (g < NTRIG - 1) begin : g_next
            assign next_dbg[g] = s_q.ctl[g+1].dbg_only;
        end else begin : g_last
            assign next_dbg[g] = 1'b0;
        end

        if (g > 0) begin : g_prev
            assign prev_lock[g] = !s_q.ctl[g-1].dbg_only && s_q.ctl[g-1].chain;
        end else begin : g_first
            assign prev_lock[g] = 1'b0;
        end
    end

    logic                   ch_any;
    logic [IDXW-1:0]        ch_idx;
    logic [3:0]             ch_action;
    logic [NTRIG-1:0]       ch_members;

    mt_chain #(.NTRIG(NTRIG)) u_chain (
        .link_match   (t_match),
        .link_chain   (t_chain),
        .link_action  (t_action),
        .m_block      ((acc_priv == PRIV_M) && !s_q.en),
        .any_fire     (ch_any),
        .first_idx    (ch_idx),
        .first_action (ch_action),
        .members      (ch_members)
    );

    mt_ctl_t new_ctl;
    logic    locked;

    always_comb begin
        s_d     = s_q;
        new_ctl = '0;
        locked  = 1'b0;

        s_d.fire_v = acc_valid && ch_any;
        s_d.fire_a = (acc_valid && ch_any) ? ch_action : 4'd0;
        s_d.fire_i = (acc_valid && ch_any) ? ch_idx : '0;
        s_d.hits   = acc_valid ? ch_members : '0;

        if (reg_wr) begin
            if (reg_addr == RA_ENA) begin
                s_d.en       = reg_wdata[0];
                s_d.en_saved = reg_wdata[1];
            end
            for (int i = 0; i < NTRIG; i++) begin
                if (reg_idx == IDXW'(i)) begin
                    locked = s_q.ctl[i].dbg_only && !dbg_mode;
                    if (reg_addr == RA_CMP && !locked) begin
                        s_d.cmp[i] = reg_wdata;
                    end
                    if (reg_addr == RA_CTL && !locked) begin
                        new_ctl = ctl_unpack(reg_wdata);
                        if (!dbg_mode) new_ctl.dbg_only = 1'b0;
                        if (!(new_ctl.dbg_only && prev_lock[i])) begin
                            if (!new_ctl.dbg_only && next_dbg[i]) new_ctl.chain = 1'b0;
                            s_d.ctl[i] = new_ctl;
                        end
                    end
                end
            end
        end

        // firing sets hit after any same-cycle write
        for (int i = 0; i < NTRIG; i++) begin
            if (acc_valid && ch_members[i]) s_d.ctl[i].hit = 1'b1;
        end

        if (trap_m) begin
            s_d.en_saved = s_q.en;
            s_d.en       = 1'b0;
        end else if (mret) begin
            s_d.en = s_q.en_saved;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RA_ENA) begin
            reg_rdata[1:0] = {s_q.en_saved, s_q.en};
        end else begin
            for (int i = 0; i < NTRIG; i++) begin
                if (reg_idx == IDXW'(i)) begin
                    if (reg_addr == RA_CTL) reg_rdata = ctl_pack(s_q.ctl[i]);
                    if (reg_addr == RA_CMP) reg_rdata = s_q.cmp[i];
                end
            end
        end
    end

    logic ena_q;
    logic ena_saved_q;
    assign ena_q       = s_q.en;
    assign ena_saved_q = s_q.en_saved;

    assign fire_valid  = s_q.fire_v;
    assign fire_action = s_q.fire_a;
    assign fire_idx    = s_q.fire_i;
    assign hit_mask    = s_q.hits;

endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
    parameter  int NTRIG = 4,
    localparam int IDXW  = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             trap_m,
    input logic             mret,
    input logic             fire_valid,
    input logic [IDXW-1:0]  fire_idx,
    input logic [NTRIG-1:0] hit_mask,
    input logic             ena,
    input logic             ena_saved
);

    p_fire_after_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid |-> $past(acc_valid));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !fire_valid && hit_mask == '0);

    p_trap_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_m |=> !ena);

    p_trap_saves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_m |=> ena_saved == $past(ena));

    p_mret_restores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mret && !trap_m) |=> ena == $past(ena_saved));

    p_reporter_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid |-> hit_mask[fire_idx]);

    p_mask_agrees_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_mask != '0) |-> fire_valid);

endmodule

bind match_trig_array mt_checker #(.NTRIG(NTRIG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .trap_m     (trap_m),
    .mret       (mret),
    .fire_valid (fire_valid),
    .fire_idx   (fire_idx),
    .hit_mask   (hit_mask),
    .ena        (ena_q),
    .ena_saved  (ena_saved_q)
);

// File: tb/sim_match_trig_array.sv
module sim_match_trig_array;

    localparam int NT = 4;
    localparam logic [31:0] TYPEW = 32'h2000_0000;
    localparam logic [2:0] EX = 3'b001, LD = 3'b010, ST = 3'b100;
    localparam logic [2:0] PU = 3'b001, PS = 3'b010, PM = 3'b100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dbg_mode = 1'b0;
    logic        trap_m = 1'b0;
    logic        mret = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_ex = 1'b0, acc_ld = 1'b0, acc_st = 1'b0;
    logic [1:0]  acc_priv = '0;
    logic [2:0]  acc_size = '0;
    logic [31:0] acc_addr = '0, acc_data = '0;
    logic        fire_valid;
    logic [3:0]  fire_action;
    logic [1:0]  fire_idx;
    logic [3:0]  hit_mask;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    match_trig_array #(.NTRIG(NT), .XLEN(32)) u0 (.*);

    typedef struct packed {
        logic       fv;
        logic [3:0] act;
        logic [1:0] idx;
        logic [3:0] hm;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic  pend = 1'b0;

    always @(posedge clk) pend <= acc_valid;

    // monitor: compares each access result one cycle after it was presented
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (pend) begin
                exp_t  e;
                string t;
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R11: result with empty queue got fv=%0b", fire_valid);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (fire_valid !== e.fv || (e.fv && (fire_action !== e.act || fire_idx !== e.idx)) ||
                        hit_mask !== e.hm) begin
                        bad++;
                        $display("FAIL %s: got fv=%0b act=%0d idx=%0d hm=%b exp fv=%0b act=%0d idx=%0d hm=%b",
                                 t, fire_valid, fire_action, fire_idx, hit_mask, e.fv, e.act, e.idx, e.hm);
                    end
                end
            end else begin
                total++;
                if (fire_valid !== 1'b0 || hit_mask !== 4'b0) begin
                    bad++;
                    $display("FAIL R11: idle cycle got fv=%0b hm=%b exp fv=0 hm=0000", fire_valid, hit_mask);
                end
            end
        end
    end

    function automatic logic [31:0] cw(input logic [3:0] mode, input logic sel, input logic [2:0] kinds,
                                       input logic [2:0] privs, input logic chain, input logic [3:0] act,
                                       input logic [2:0] size, input logic dbg);
        return (32'(dbg) << 27) | (32'(size) << 16) | (32'(act) << 12) | (32'(chain) << 11) |
               (32'(privs) << 8) | (32'(kinds) << 5) | (32'(sel) << 4) | 32'(mode);
    endfunction

    task automatic wr(input logic [1:0] idx, input logic [1:0] ra, input logic [31:0] d);
        @(negedge clk);
        reg_idx = idx; reg_addr = ra; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, input logic [1:0] ra, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_idx = idx; reg_addr = ra;
        #2;
        total++;
        if (reg_rdata !== e) begin
            bad++;
            $display("FAIL %s: read got %h exp %h", t, reg_rdata, e);
        end
    endtask

    task automatic acc(input logic [2:0] kinds, input logic [1:0] pv, input logic [2:0] sz,
                       input logic [31:0] a, input logic [31:0] d,
                       input logic fv, input logic [3:0] act, input logic [1:0] idx, input logic [3:0] hm,
                       input string t);
        exp_t e;
        @(negedge clk);
        {acc_st, acc_ld, acc_ex} = kinds;
        acc_priv = pv; acc_size = sz; acc_addr = a; acc_data = d;
        acc_valid = 1'b1;
        e.fv = fv; e.act = act; e.idx = idx; e.hm = hm;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic pulse_trap();
        @(negedge clk); trap_m = 1'b1;
        @(negedge clk); trap_m = 1'b0;
    endtask

    task automatic pulse_mret();
        @(negedge clk); mret = 1'b1;
        @(negedge clk); mret = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NT; i++) wr(2'(i), 2'd0, 32'h0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd(0, 0, TYPEW, "R12");
        rd(3, 1, 32'h0, "R12");
        rd(0, 2, 32'h0, "R12");

        // R1 equality and its inverse
        wr(0, 1, 32'h1000);
        wr(0, 0, cw(0, 0, LD, PM, 0, 1, 0, 0) | 32'hF000_0000);
        rd(0, 0, TYPEW | cw(0, 0, LD, PM, 0, 1, 0, 0), "R12");
        acc(LD, 3, 3, 32'h1000, 0, 1, 1, 0, 4'b0001, "R1");
        acc(LD, 3, 3, 32'h1004, 0, 0, 0, 0, 4'b0000, "R1");
        // R8 hit set and cleared by write
        rd(0, 0, TYPEW | cw(0, 0, LD, PM, 0, 1, 0, 0) | 32'h0008_0000, "R8");
        wr(0, 0, cw(0, 0, LD, PM, 0, 1, 0, 0));
        rd(0, 0, TYPEW | cw(0, 0, LD, PM, 0, 1, 0, 0), "R8");
        wr(0, 0, cw(8, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 3, 32'h1004, 0, 1, 1, 0, 4'b0001, "R1");
        acc(LD, 3, 3, 32'h1000, 0, 0, 0, 0, 4'b0000, "R1");
        wr(0, 0, cw(6, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 3, 32'h1000, 0, 0, 0, 0, 4'b0000, "R1");
        wr(0, 0, cw(10, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 3, 32'h0, 0, 0, 0, 0, 4'b0000, "R1");
        wr(0, 0, 32'h0);

        // R2 unsigned ordering
        wr(1, 1, 32'h8000);
        wr(1, 0, cw(2, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 3, 32'h8000, 0, 1, 1, 1, 4'b0010, "R2");
        acc(LD, 3, 3, 32'h7FFF, 0, 0, 0, 0, 4'b0000, "R2");
        wr(1, 0, cw(3, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 3, 32'h7FFF, 0, 1, 1, 1, 4'b0010, "R2");
        acc(LD, 3, 3, 32'hFFFF_FFFF, 0, 0, 0, 0, 4'b0000, "R2");

        // R3 power-of-two range
        wr(1, 1, 32'h1007);
        wr(1, 0, cw(1, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 3, 32'h100F, 0, 1, 1, 1, 4'b0010, "R3");
        acc(LD, 3, 3, 32'h1000, 0, 1, 1, 1, 4'b0010, "R3");
        acc(LD, 3, 3, 32'h1010, 0, 0, 0, 0, 4'b0000, "R3");
        wr(1, 0, cw(9, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 3, 32'h1010, 0, 1, 1, 1, 4'b0010, "R3");
        acc(LD, 3, 3, 32'h1008, 0, 0, 0, 0, 4'b0000, "R3");

        // R4 half-word masked compares
        wr(1, 1, 32'hFF00_1200);
        wr(1, 0, cw(4, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 3, 32'h0000_12AB, 0, 1, 1, 1, 4'b0010, "R4");
        acc(LD, 3, 3, 32'h0000_13AB, 0, 0, 0, 0, 4'b0000, "R4");
        wr(1, 0, cw(12, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 3, 32'h0000_13AB, 0, 1, 1, 1, 4'b0010, "R4");
        wr(1, 0, cw(5, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 3, 32'h12AB_0000, 0, 1, 1, 1, 4'b0010, "R4");
        acc(LD, 3, 3, 32'h1300_0000, 0, 0, 0, 0, 4'b0000, "R4");
        wr(1, 0, cw(13, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 3, 32'h1300_0000, 0, 1, 1, 1, 4'b0010, "R4");

        // R5 size filter
        wr(1, 1, 32'h2000);
        wr(1, 0, cw(0, 0, LD, PM, 0, 1, 1, 0));
        acc(LD, 3, 1, 32'h2000, 0, 1, 1, 1, 4'b0010, "R5");
        acc(LD, 3, 3, 32'h2000, 0, 0, 0, 0, 4'b0000, "R5");
        wr(1, 0, cw(0, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 5, 32'h2000, 0, 1, 1, 1, 4'b0010, "R5");

        // R6 data select, kind and privilege filters
        wr(1, 1, 32'hDEAD_BEEF);
        wr(1, 0, cw(0, 1, ST, PU, 0, 2, 0, 0));
        acc(ST, 0, 3, 32'h0, 32'hDEAD_BEEF, 1, 2, 1, 4'b0010, "R6");
        acc(ST, 1, 3, 32'h0, 32'hDEAD_BEEF, 0, 0, 0, 4'b0000, "R6");
        acc(LD, 0, 3, 32'h0, 32'hDEAD_BEEF, 0, 0, 0, 4'b0000, "R6");
        acc(ST, 0, 3, 32'hDEAD_BEEF, 32'h0, 0, 0, 0, 4'b0000, "R6");
        acc(EX, 0, 3, 32'h0, 32'hDEAD_BEEF, 0, 0, 0, 4'b0000, "R6");
        wr(1, 0, 32'h0);

        // R7 chaining
        wr(0, 1, 32'h3000);
        wr(0, 0, cw(0, 0, LD, PM, 1, 5, 0, 0));
        wr(1, 1, 32'h55);
        wr(1, 0, cw(0, 1, LD, PM, 0, 3, 0, 0));
        acc(LD, 3, 3, 32'h3000, 32'h55, 1, 3, 1, 4'b0011, "R7");
        acc(LD, 3, 3, 32'h3000, 32'h56, 0, 0, 0, 4'b0000, "R7");
        acc(LD, 3, 3, 32'h3004, 32'h55, 0, 0, 0, 4'b0000, "R7");
        wr(0, 0, cw(0, 0, LD, PM, 0, 5, 0, 0));
        acc(LD, 3, 3, 32'h3004, 32'h55, 1, 3, 1, 4'b0010, "R7");
        // R13 two standalone triggers: lowest index reports
        acc(LD, 3, 3, 32'h3000, 32'h55, 1, 5, 0, 4'b0011, "R13");
        clear_all();
        wr(2, 1, 32'h6000);
        wr(2, 0, cw(0, 0, LD, PM, 0, 4, 0, 0));
        wr(3, 1, 32'h6000);
        wr(3, 0, cw(0, 0, LD, PM, 0, 6, 0, 0));
        acc(LD, 3, 3, 32'h6000, 0, 1, 4, 2, 4'b1100, "R13");
        wr(2, 0, 32'h0);
        wr(3, 0, cw(0, 0, LD, PM, 1, 6, 0, 0));
        acc(LD, 3, 3, 32'h6000, 0, 0, 0, 0, 4'b0000, "R7");
        clear_all();

        // R9 machine enable with trap and return
        wr(0, 1, 32'h4000);
        wr(0, 0, cw(0, 0, LD, PM | PU, 0, 0, 0, 0));
        acc(LD, 3, 3, 32'h4000, 0, 0, 0, 0, 4'b0000, "R9");
        acc(LD, 0, 3, 32'h4000, 0, 1, 0, 0, 4'b0001, "R9");
        wr(0, 2, 32'h1);
        acc(LD, 3, 3, 32'h4000, 0, 1, 0, 0, 4'b0001, "R9");
        pulse_trap();
        rd(0, 2, 32'h2, "R9");
        acc(LD, 3, 3, 32'h4000, 0, 0, 0, 0, 4'b0000, "R9");
        pulse_mret();
        rd(0, 2, 32'h3, "R9");
        acc(LD, 3, 3, 32'h4000, 0, 1, 0, 0, 4'b0001, "R9");
        pulse_trap();
        wr(0, 0, cw(0, 0, LD, PM, 0, 1, 0, 0));
        acc(LD, 3, 3, 32'h4000, 0, 1, 1, 0, 4'b0001, "R9");
        clear_all();

        // R10 debug-only protection
        dbg_mode = 1'b1;
        wr(1, 1, 32'h77);
        wr(1, 0, cw(0, 0, LD, PM, 0, 2, 0, 1));
        rd(1, 0, TYPEW | cw(0, 0, LD, PM, 0, 2, 0, 1), "R10");
        dbg_mode = 1'b0;
        wr(0, 0, cw(0, 0, LD, PM, 1, 1, 0, 0));
        rd(0, 0, TYPEW | cw(0, 0, LD, PM, 0, 1, 0, 0), "R10");
        wr(1, 0, cw(3, 0, ST, PU, 0, 7, 0, 0));
        rd(1, 0, TYPEW | cw(0, 0, LD, PM, 0, 2, 0, 1), "R10");
        wr(1, 1, 32'h99);
        rd(1, 1, 32'h77, "R10");
        wr(2, 0, cw(0, 0, LD, PM, 0, 1, 0, 1));
        rd(2, 0, TYPEW | cw(0, 0, LD, PM, 0, 1, 0, 0), "R10");
        dbg_mode = 1'b1;
        wr(0, 0, cw(0, 0, LD, PM, 1, 1, 0, 1));
        rd(0, 0, TYPEW | cw(0, 0, LD, PM, 1, 1, 0, 1), "R10");
        wr(2, 0, cw(0, 0, LD, PM, 1, 1, 0, 0));
        wr(3, 0, cw(0, 0, LD, PM, 0, 2, 0, 1));
        rd(3, 0, TYPEW, "R10");
        dbg_mode = 1'b0;

        // R11 quiet outputs over idle cycles, queue drained
        repeat (4) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R11: pending results got %0d exp 0", exp_q.size());
        end
        finish_run();
    end

endmodule